// File: doc/BRIEF.md
# Eight-Channel Countdown Timer Bank

This block holds a set of independent 32-bit down-counters that share one register window on a simple valid/write/address/data bus. Each channel has a byte-wide control register and a 32-bit count register. Software loads the count while the channel is stopped. It then sets the enable bit together with a two-bit mode. The channel either runs freely and wraps, expires once and stops, or expires and reloads again and again. Every channel drives its own interrupt line.

Channel `c` decodes at byte offset `8*c` for control and `8*c + 4` for count. Address bits [1:0] are not decoded. Reads are registered: the data and a valid flag appear one cycle after the request. A count read returns the value the counter held in the request cycle.

Top module: `tmr_bank`

## Requirements
- R1: While reset is high and after it is released, every control and count register reads 0, every interrupt line is 0, and the read data is 0.
- R2: A control write keeps write-data bits [7:0] only. A control read returns that byte zero-extended. Bit 0 is the enable and bits [5:4] are the mode.
- R3: A count write loads both the live counter and the reload value. While the channel is disabled the counter holds that value, and reads return it.
- R4: An enabled counter decrements by exactly one on every clock edge after the edge that set the enable, including the edge that clears it.
- R5: Mode 0, and the reserved mode 3, run freely. The counter wraps from 0 to 0xFFFFFFFF and the channel never raises its interrupt.
- R6: Mode 1 is one-shot. On the edge where the counter goes from 1 to 0, the channel pulses its interrupt for exactly one cycle. On that same edge it clears control bit 0 and keeps the mode bits, so the counter stays at 0.
- R7: Mode 2 is periodic. On the edge where the counter would go from 1 to 0, it instead reloads the last written count and pulses its interrupt. A load of L therefore fires once every L cycles.
- R8: Channels are independent. A write to one channel changes no other channel's registers, and interrupt line c is driven only by channel c.
- R9: Writing 0 to a control register stops that channel. Its count then stays frozen and it raises no further interrupt.
- R10: A read request produces read-valid high and its data in the next cycle. A write request produces no read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | 8 | One interrupt pulse line per channel |

## Verification
The hardest condition to reach is an expiry that lands on the same edge as a bus write to that channel, or on the edge that stops it. That case needs exact cycle alignment across several channels at once. The random rounds load all eight channels with different counts and modes and enable them on consecutive edges. They then stop them on consecutive edges, so every channel runs for the same known number of edges. Short periodic and one-shot loads then expire on or near the stop edge, and the bench computes the final counts and the number of pulses in closed form. Directed cases pin down the exact cycle of the one-shot pulse and the wrap from zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_FREE   = 2'd0,
    TM_ONCE   = 2'd1,
    TM_RELOAD = 2'd2,
    TM_RSVD   = 2'd3
  } tm_mode_e;

  localparam int CTL_W    = 8;
  localparam int EN_BIT   = 0;
  localparam int MODE_LSB = 4;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int N_CH   = 8,
  parameter int ADDR_W = 6,
  parameter int CH_W   = 3
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [N_CH-1:0]   ctl_we,
  output logic [N_CH-1:0]   cnt_we,
  output logic              rd_en,
  output logic [CH_W-1:0]   rd_sel,
  output logic              rd_is_cnt
);

  logic [CH_W-1:0] ch_idx;
  logic            is_cnt;
  logic            wr_req;

  assign ch_idx    = bus_addr[ADDR_W-1:3];
  assign is_cnt    = bus_addr[2];
  assign wr_req    = bus_valid && bus_write;
  assign rd_en     = bus_valid && !bus_write;
  assign rd_sel    = ch_idx;
  assign rd_is_cnt = is_cnt;

  for (genvar c = 0; c < N_CH; c++) begin : g_strobe
    assign ctl_we[c] = wr_req && (ch_idx == CH_W'(c)) && !is_cnt;
    assign cnt_we[c] = wr_req && (ch_idx == CH_W'(c)) &&  is_cnt;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_o
);

  logic [CTL_W-1:0] ctl_r;
  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] reload_r;
  logic             irq_r;
  tm_mode_e         mode;
  logic             en;
  logic             expires;
  logic             at_one;

  assign mode    = tm_mode_e'(ctl_r[MODE_LSB+1:MODE_LSB]);
  assign en      = ctl_r[EN_BIT];
  assign at_one  = (cnt_r == CNT_W'(1));
  assign expires = en && at_one && (mode == TM_ONCE || mode == TM_RELOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r <= '0;
    end else if (ctl_we) begin
      ctl_r <= wdata[CTL_W-1:0];
    end else if (expires && mode == TM_ONCE) begin
      ctl_r[EN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_r    <= '0;
      reload_r <= '0;
    end else if (cnt_we) begin
      cnt_r    <= wdata;
      reload_r <= wdata;
    end else if (en) begin
      if (expires && mode == TM_RELOAD) cnt_r <= reload_r;
      else                              cnt_r <= cnt_r - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_r <= 1'b0;
    else     irq_r <= expires;
  end

  assign ctl_q = ctl_r;
  assign cnt_q = cnt_r;
  assign irq_o = irq_r;

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !cnt_we && !(at_one && mode inside {TM_ONCE, TM_RELOAD}))
      |=> (cnt_r == $past(cnt_r) - CNT_W'(1)));

  assert_free_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (en && (mode == TM_FREE || mode == TM_RSVD)) |=> !irq_o);

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (en && at_one && mode == TM_ONCE && !ctl_we && !cnt_we)
      |=> (irq_o && !ctl_r[EN_BIT] && cnt_r == '0));

  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (en && at_one && mode == TM_RELOAD && !cnt_we)
      |=> (irq_o && cnt_r == reload_r));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_we) |=> $stable(cnt_r));

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int N_CH  = 8,
  parameter int CNT_W = 32,
  parameter int CH_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [CH_W-1:0]             rd_sel,
  input  logic                        rd_is_cnt,
  input  logic [N_CH-1:0][CTL_W-1:0]  ctl_all,
  input  logic [N_CH-1:0][CNT_W-1:0]  cnt_all,
  output logic [CNT_W-1:0]            rdata,
  output logic                        rvalid
);

  localparam int PAD_W = CNT_W - CTL_W;

  logic [CNT_W-1:0] sel_word;

  always_comb begin
    if (rd_is_cnt) sel_word = cnt_all[rd_sel];
    else           sel_word = {{PAD_W{1'b0}}, ctl_all[rd_sel]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= sel_word;
    end
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 32,
  parameter int CH_W   = $clog2(N_CH),
  parameter int ADDR_W = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic [N_CH-1:0]   irq
);

  logic [N_CH-1:0]             ctl_we;
  logic [N_CH-1:0]             cnt_we;
  logic                        rd_en;
  logic [CH_W-1:0]             rd_sel;
  logic                        rd_is_cnt;
  logic [N_CH-1:0][CTL_W-1:0]  ctl_all;
  logic [N_CH-1:0][CNT_W-1:0]  cnt_all;

  tmr_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .ctl_we    (ctl_we),
    .cnt_we    (cnt_we),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .rd_is_cnt (rd_is_cnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .ctl_we (ctl_we[c]),
      .cnt_we (cnt_we[c]),
      .wdata  (bus_wdata),
      .ctl_q  (ctl_all[c]),
      .cnt_q  (cnt_all[c]),
      .irq_o  (irq[c])
    );
  end

  tmr_rdmux #(.N_CH(N_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .rd_is_cnt (rd_is_cnt),
    .ctl_all   (ctl_all),
    .cnt_all   (cnt_all),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_wr_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  assert_irq_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && bus_rdata == '0));

endmodule

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;

  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NC-1:0] irq;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  int irq_cnt [NC];

  always #2 clk = ~clk;

  tmr_bank dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  initial for (int i = 0; i < NC; i++) irq_cnt[i] = 0;

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NC; i++) if (irq[i]) irq_cnt[i]++;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int ch, input bit is_cnt, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = 6'(ch * 8 + (is_cnt ? 4 : 0)); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int ch, input bit is_cnt, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0;
    bus_addr = 6'(ch * 8 + (is_cnt ? 4 : 0));
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_cnt(int unsigned l, int md, int unsigned n);
    if (md == 1) return (n >= l) ? 32'd0 : 32'(l - n);
    if (md == 2) return ((n % l) == 0) ? 32'(l) : 32'(l - (n % l));
    return 32'(l) - 32'(n);
  endfunction

  function automatic int exp_irq(int unsigned l, int md, int unsigned n);
    if (md == 1) return (n >= l) ? 1 : 0;
    if (md == 2) return int'(n / l);
    return 0;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog got=%h exp=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] v, v2;
    int base [NC];
    int unsigned ll [NC];
    int mm [NC];
    v = $urandom(32'h5EED_1234);

    // R1: reset values, checked while reset is still high
    repeat (3) @(negedge clk);
    check("R1 irq in reset", 32'(irq), 32'd0);
    check("R1 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      rd(c, 0, v); check("R1 ctl", v, 32'd0);
      rd(c, 1, v); check("R1 cnt", v, 32'd0);
    end
    check("R1 irq", 32'(irq), 32'd0);

    // R2: only the low control byte is kept
    wr(3, 0, 32'hABCD_1220);
    check("R10 no rvalid on write", 32'(bus_rvalid), 32'd0);
    rd(3, 0, v);
    check("R2 ctl byte", v, 32'h0000_0020);
    check("R10 rvalid on read", 32'(bus_rvalid), 32'd1);

    // R3: count load holds while disabled
    wr(3, 1, 32'h1234_5678);
    rd(3, 1, v); check("R3 load", v, 32'h1234_5678);
    repeat (5) @(negedge clk);
    rd(3, 1, v); check("R3 hold", v, 32'h1234_5678);

    // R4: one step per edge
    wr(1, 1, 32'd1000);
    wr(1, 0, 32'h01);
    rd(1, 1, v);  check("R4 first", v, 32'd1000);
    rd(1, 1, v2); check("R4 second", v2, 32'd999);
    wr(1, 0, 32'h00);
    rd(1, 1, v); check("R4 stopped", v, 32'd997);

    // R5: free-run wrap, mode 0 and mode 3
    for (int i = 0; i < NC; i++) base[i] = irq_cnt[i];
    wr(2, 1, 32'd2);
    wr(2, 0, 32'h01);
    repeat (4) @(negedge clk);
    wr(2, 0, 32'h00);
    rd(2, 1, v); check("R5 wrap mode0", v, 32'hFFFF_FFFD);
    wr(7, 1, 32'd1);
    wr(7, 0, 32'h31);
    repeat (2) @(negedge clk);
    wr(7, 0, 32'h00);
    rd(7, 1, v); check("R5 wrap mode3", v, 32'hFFFF_FFFE);
    check("R5 no irq ch2", 32'(irq_cnt[2] - base[2]), 32'd0);
    check("R5 no irq ch7", 32'(irq_cnt[7] - base[7]), 32'd0);

    // R6: one-shot pulse timing and self-stop
    for (int i = 0; i < NC; i++) base[i] = irq_cnt[i];
    wr(4, 1, 32'd3);
    wr(4, 0, 32'h11);
    @(negedge clk); @(negedge clk);
    check("R6 before expiry", 32'(irq[4]), 32'd0);
    @(negedge clk);
    check("R6 pulse", 32'(irq[4]), 32'd1);
    @(negedge clk);
    check("R6 pulse ends", 32'(irq[4]), 32'd0);
    repeat (6) @(negedge clk);
    rd(4, 0, v); check("R6 enable cleared", v, 32'h10);
    rd(4, 1, v); check("R6 count zero", v, 32'd0);
    check("R6 single pulse", 32'(irq_cnt[4] - base[4]), 32'd1);

    // R7: periodic reload, 20 edges with load 4
    for (int i = 0; i < NC; i++) base[i] = irq_cnt[i];
    wr(5, 1, 32'd4);
    wr(5, 0, 32'h21);
    repeat (19) @(negedge clk);
    wr(5, 0, 32'h00);
    @(negedge clk);
    check("R7 pulses", 32'(irq_cnt[5] - base[5]), 32'd5);
    rd(5, 1, v); check("R7 reloaded", v, 32'd4);
    // R8: no other line fired, other channels untouched
    for (int i = 0; i < NC; i++)
      if (i != 5) check("R8 other irq", 32'(irq_cnt[i] - base[i]), 32'd0);
    rd(3, 1, v); check("R8 ch3 kept", v, 32'h1234_5678);

    // R9: stop freezes count
    for (int i = 0; i < NC; i++) base[i] = irq_cnt[i];
    wr(6, 1, 32'd100);
    wr(6, 0, 32'h21);
    repeat (3) @(negedge clk);
    wr(6, 0, 32'h00);
    rd(6, 1, v); check("R9 frozen", v, 32'd96);
    repeat (5) @(negedge clk);
    rd(6, 1, v); check("R9 still frozen", v, 32'd96);
    check("R9 no irq", 32'(irq_cnt[6] - base[6]), 32'd0);

    // Random rounds: all channels, mixed modes, same run length (R4 R5 R6 R7 R8)
    for (int r = 0; r < 6; r++) begin
      int unsigned w;
      for (int c = 0; c < NC; c++) begin
        ll[c] = 1 + ($urandom % 60);
        mm[c] = int'($urandom % 3);
        wr(c, 1, 32'(ll[c]));
      end
      @(negedge clk);
      for (int c = 0; c < NC; c++) base[c] = irq_cnt[c];
      for (int c = 0; c < NC; c++) wr(c, 0, 32'((mm[c] << 4) | 1));
      w = 20 + ($urandom % 150);
      repeat (w) @(negedge clk);
      for (int c = 0; c < NC; c++) wr(c, 0, 32'h00);
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        rd(c, 1, v);
        check("R8 random count", v, exp_cnt(ll[c], mm[c], w + 8));
        check("R8 random irqs", 32'(irq_cnt[c] - base[c]), 32'(exp_irq(ll[c], mm[c], w + 8)));
      end
    end

    summary();
  end

endmodule